// File: doc/BRIEF.md
# Repeat-Accumulate LDPC Parity Encoder

This block produces the parity of a systematic LDPC codeword whose parity-check matrix ends in a dual-diagonal (staircase) section. A frame begins with a start pulse that selects one of two code rates. The information bits then arrive four per clock. Each bit is XORed into a set of parity accumulator bits. Their addresses are generated on the fly from a compact per-group rule rather than from a full connection matrix. Once the last information beat has been absorbed, the block runs a forward running-XOR pass over the accumulators and emits the finished parity, four bits per clock.

The output stream carries the information bits unchanged first, one cycle after each accepted beat. The parity beats follow immediately in ascending index order, and a last flag marks the final beat. Bits are grouped in blocks of GRP (16 by default). Each group uses WD (3) base entries. Rate 0 has K=32 and M=64 parity bits, and rate 1 has K=64 and M=32.

Top module: `ldpc_ira_enc`

## Requirements
- R1: While reset is held and right after it, dout_valid, dout_last and in_ready are all low.
- R2: A start pulse while idle latches rate_sel and clears every parity accumulator. in_ready then rises on the following cycle and stays high until K/4 beats have been accepted.
- R3: Each beat accepted with din_valid and in_ready appears on dout unchanged on the next cycle, with dout_valid high. Bit b of beat i is information bit 4i+b.
- R4: Information bit m lies in group g=m/16 with offset k=m%16. For entry j in 0..2 it toggles accumulator (x + k*q) mod M, where x = (7g + j*(q + M/2) + 3) mod M and q = M/16.
- R5: When several bits of one beat, or several entries, hit the same accumulator address, their contributions combine by XOR, so an even number of hits leaves the address unchanged.
- R6: Right after the last systematic beat, M/4 parity beats follow on consecutive cycles. Bit b of parity beat i is p[4i+b], where p[0]=a[0] and p[n]=a[n] XOR p[n-1], computed from the final accumulators a.
- R7: dout_last is high on the final parity beat of a frame and on no other cycle, and the block is idle after it.
- R8: A start pulse while a frame is in progress has no effect on the current frame, and it does not begin a new frame.
- R9: Idle cycles with din_valid low inside the information phase are allowed and change neither the output nor the parity.
- R10: rate_sel=0 selects K=32, M=64 and rate_sel=1 selects K=64, M=32. These values set both the beat counts and the address rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start pulse, taken only while idle |
| rate_sel | input | 1 | Code rate select, sampled with start |
| din_valid | input | 1 | Information beat valid |
| din | input | 4 | Four information bits, bit 0 first |
| in_ready | output | 1 | High while information beats are accepted |
| dout_valid | output | 1 | Output beat valid |
| dout | output | 4 | Systematic or parity bits |
| dout_last | output | 1 | Final parity beat of the frame |

## Verification
The hardest case to reach is an accumulator that receives an even number of hits within a single beat. There the merged contribution must cancel, where a read-modify-write with a lost update would leave a one. The address rule places entries 0 and 2 exactly 2q apart, so bit k of entry 0 and bit k-2 of entry 2 always collide. An alternating 0101 beat pattern therefore forces two-way hits in every beat, and random patterns mix odd and even hit counts. Start pulses sent in the middle of a frame with the other rate, together with stalled input beats, exercise the paths that must leave the frame untouched.

// File: rtl/ldpc_ira_enc.sv
module ldpc_ira_enc #(
  parameter int PAR = 4,
  parameter int GRP = 16,
  parameter int WD  = 3,
  parameter int M0  = 64,
  parameter int KG0 = 2,
  parameter int M1  = 32,
  parameter int KG1 = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           rate_sel,
  input  logic           din_valid,
  input  logic [PAR-1:0] din,
  output logic           in_ready,
  output logic           dout_valid,
  output logic [PAR-1:0] dout,
  output logic           dout_last
);
  localparam int MMAX = (M0 > M1) ? M0 : M1;
  localparam int KB0  = KG0 * GRP / PAR;
  localparam int KB1  = KG1 * GRP / PAR;
  localparam int PB0  = M0 / PAR;
  localparam int PB1  = M1 / PAR;
  localparam int BMAX = (KB0 > KB1 ? KB0 : KB1) > (PB0 > PB1 ? PB0 : PB1) ?
                        (KB0 > KB1 ? KB0 : KB1) : (PB0 > PB1 ? PB0 : PB1);
  localparam int BW   = $clog2(BMAX + 1);
  localparam int BPG  = GRP / PAR;

  typedef enum logic [1:0] {S_IDLE, S_ABS, S_PAR} st_t;

  st_t             state;
  logic            rate_q;
  logic [BW-1:0]   cnt;
  logic [MMAX-1:0] acc, mask;
  logic            carry;
  logic [PAR-1:0]  seg, pbits;

  wire [BW-1:0] kb_end = rate_q ? BW'(KB1 - 1) : BW'(KB0 - 1);
  wire [BW-1:0] pb_end = rate_q ? BW'(PB1 - 1) : BW'(PB0 - 1);

  assign in_ready = (state == S_ABS);
  assign seg      = PAR'(acc >> (int'(cnt) * PAR));

  function automatic int base_x(logic r, int g, int j);
    int m, q;
    m = r ? M1 : M0;
    q = m / GRP;
    return (7 * g + j * (q + m / 2) + 3) % m;
  endfunction

  always_comb begin
    int g, kbase, m, q, a;
    m     = rate_q ? M1 : M0;
    q     = m / GRP;
    g     = int'(cnt) / BPG;
    kbase = (int'(cnt) % BPG) * PAR;
    mask  = '0;
    for (int j = 0; j < WD; j++) begin
      for (int b = 0; b < PAR; b++) begin
        a    = (base_x(rate_q, g, j) + (kbase + b) * q) % m;
        mask = mask ^ (MMAX'(din[b]) << a);
      end
    end
  end

  always_comb begin
    logic c;
    c = carry;
    for (int b = 0; b < PAR; b++) begin
      c        = c ^ seg[b];
      pbits[b] = c;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rate_q     <= 1'b0;
      cnt        <= '0;
      acc        <= '0;
      carry      <= 1'b0;
      dout       <= '0;
      dout_valid <= 1'b0;
      dout_last  <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      dout_last  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          rate_q <= rate_sel;
          acc    <= '0;
          cnt    <= '0;
          state  <= S_ABS;
        end
        S_ABS: if (din_valid) begin
          acc        <= acc ^ mask;
          dout       <= din;
          dout_valid <= 1'b1;
          if (cnt == kb_end) begin
            cnt   <= '0;
            carry <= 1'b0;
            state <= S_PAR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          dout       <= pbits;
          dout_valid <= 1'b1;
          carry      <= pbits[PAR-1];
          if (cnt == pb_end) begin
            dout_last <= 1'b1;
            cnt       <= '0;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SYS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && din_valid) |=> (dout_valid && dout == $past(din))); // R3
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> (acc == '0)); // R2
  AST_READY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(start)); // R2
  AST_PARITY_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAR) |=> dout_valid); // R6
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dout_last |-> (dout_valid && !in_ready)); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != S_IDLE) |=> $stable(rate_q)); // R8
endmodule

// File: tb/tb_ldpc_ira_enc.sv
module tb_ldpc_ira_enc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rate_sel = 1'b0, din_valid = 1'b0;
  logic [3:0] din = '0;
  logic in_ready, dout_valid, dout_last;
  logic [3:0] dout;

  int checks = 0, errors = 0, cycles = 0;

  typedef struct packed { logic [3:0] d; logic last; logic par; } item_t;
  item_t exp_q[$];

  ldpc_ira_enc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel),
    .din_valid(din_valid), .din(din), .in_ready(in_ready),
    .dout_valid(dout_valid), .dout(dout), .dout_last(dout_last)
  );

  always #4 clk = ~clk;

  function automatic int bx(int m, int g, int j);
    int q;
    q = m / 16;
    return (7 * g + j * (q + m / 2) + 3) % m;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n && dout_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R6 unexpected beat: actual %h, expected none", dout);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (dout !== e.d) begin
          errors++;
          $display("FAIL %s data: actual %h, expected %h", e.par ? "R6" : "R3", dout, e.d);
        end
        if (dout_last !== e.last) begin
          errors++;
          $display("FAIL R7 last: actual %b, expected %b", dout_last, e.last);
        end
      end
    end else if (rst_n && dout_last) begin
      checks++; errors++;
      $display("FAIL R7 last without valid: actual 1, expected 0");
    end
  end

  // kind: 0 zeros, 1 ones, 2 single bit, 3 random, 4 alternating (R5 collisions)
  task automatic run_frame(input int rate, input int kind, input bit gaps, input bit busy_start);
    int k, m, q;
    bit info[64];
    bit acc[64];
    bit p[64];
    k = rate ? 64 : 32;   // R10
    m = rate ? 32 : 64;
    q = m / 16;
    for (int i = 0; i < 64; i++) begin acc[i] = 0; p[i] = 0; end
    for (int i = 0; i < k; i++) begin
      case (kind)
        0: info[i] = 0;
        1: info[i] = 1;
        2: info[i] = (i == 5);
        3: info[i] = 1'($urandom);
        default: info[i] = (i % 2 == 0);
      endcase
    end
    for (int i = 0; i < k; i++)       // R4 address rule, R5 XOR merge
      if (info[i])
        for (int j = 0; j < 3; j++) begin
          int a;
          a = (bx(m, i / 16, j) + (i % 16) * q) % m;
          acc[a] = ~acc[a];
        end
    for (int i = 0; i < m; i++) p[i] = (i == 0) ? acc[0] : (acc[i] ^ p[i-1]);  // R6
    for (int i = 0; i < k / 4; i++)
      exp_q.push_back('{d: {info[4*i+3], info[4*i+2], info[4*i+1], info[4*i]}, last: 1'b0, par: 1'b0});
    for (int i = 0; i < m / 4; i++)
      exp_q.push_back('{d: {p[4*i+3], p[4*i+2], p[4*i+1], p[4*i]}, last: (i == m/4 - 1), par: 1'b1});

    @(negedge clk); start = 1'b1; rate_sel = rate[0];
    @(negedge clk); start = 1'b0;
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R2 in_ready after start: actual %b, expected 1", in_ready);
    end
    for (int i = 0; i < k / 4; i++) begin
      if (gaps && (i % 3 == 1)) begin   // R9 stall cycle
        din_valid = 1'b0; din = 4'hF;
        @(negedge clk);
      end
      din_valid = 1'b1;
      din = {info[4*i+3], info[4*i+2], info[4*i+1], info[4*i]};
      start = busy_start && (i == 2);   // R8 start while busy
      rate_sel = busy_start ? ~rate[0] : rate[0];
      @(negedge clk);
      start = 1'b0;
    end
    din_valid = 1'b0; din = '0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R8/R7 idle after frame: actual in_ready %b, expected 0", in_ready);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;   // R1
    if (dout_valid !== 1'b0 || dout_last !== 1'b0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b%b%b, expected 000", dout_valid, dout_last, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dout_valid !== 1'b0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: actual %b%b, expected 00", dout_valid, in_ready);
    end
    run_frame(0, 0, 0, 0);
    run_frame(0, 2, 0, 0);
    run_frame(1, 2, 0, 0);
    run_frame(0, 4, 0, 0);
    run_frame(1, 4, 0, 0);
    run_frame(0, 1, 1, 0);
    run_frame(1, 3, 1, 1);
    run_frame(0, 3, 0, 1);
    for (int r = 0; r < 4; r++) run_frame(r % 2, 3, r[1], 0);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 missing beats: actual %0d left, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule